// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM Core

This block is a synchronous single-port memory with a word split into byte lanes. On every rising clock edge it can take a whole-word write, a write of selected lanes, or a read. An upstream burst sequencer supplies the address. A select input marks the cycles that carry an access.

Reads are pipelined. The word at the address presented at one edge sits in an output register after that edge. An asynchronous active-low output enable then lets that word onto the bus. The bus is split into an input half, an output half and a drive-enable output, which the pad ring uses to build the bidirectional pins.

The first read after any idle cycle has its drive suppressed for one cycle. A sleep input freezes all activity and keeps the stored contents.

Top module: `pbsram_core`

## Requirements
- R1: When `gw_n` is low in an active cycle, all lanes of `mem[addr]` take `dq_i`, whatever `bwe_n` and `bsel_n` are.
- R2: When `gw_n` is high and `bwe_n` is low in an active cycle, lane i (bits `8*i+7:8*i`) of `mem[addr]` takes `dq_i` only if `bsel_n[i]` is low. The other lanes keep their contents.
- R3: An active cycle with both `gw_n` and `bwe_n` high is a read. It changes no stored data, even when some `bsel_n` bits are low.
- R4: A read issued at an edge puts the word stored at that address on `dq_o` right after that same edge. It stays there through the following cycle.
- R5: `dq_en` is high only in the cycle after a read, and only while `oe_n` is low. `oe_n` acts without waiting for a clock edge.
- R6: A read whose previous edge was idle (select low, sleep high, or reset) has `dq_en` held low in its output cycle. A read that directly follows an active cycle is driven normally.
- R7: While `sleep` is high, no write takes effect, no read is issued and `dq_en` is low. The stored contents are kept.
- R8: When `sel` is low at an edge, nothing is written or read, and `dq_en` is low in the next cycle. `dq_en` is low after reset.
- R9: `dq_o` keeps its value across every edge at which no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sel | input | 1 | Access select, high when the cycle carries an access |
| sleep | input | 1 | Active-high low-activity state |
| addr | input | $clog2(DEPTH) | Word address from the burst sequencer |
| gw_n | input | 1 | Active-low whole-word write |
| bwe_n | input | 1 | Active-low lane-write enable |
| bsel_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_i | input | LANES*8 | Write data from the pins |
| dq_o | output | LANES*8 | Registered read data |
| dq_en | output | 1 | Pin drive enable |

## Verification
The bench builds the core with DEPTH set to 64 and the default four 8-bit lanes. The small depth puts the topmost address within a short run, so the address edge is exercised along with the low ones. With four lanes, several mixed byte-select patterns can be checked against a reference array, each keeping some lanes and overwriting others. Every cycle the bench checks both the drive enable and the held read word. This covers the masked first read after idle and after sleep, as well as output enable toggling between back-to-back reads.

// File: rtl/pbsram_core.sv
module pbsram_core #(
  parameter int DEPTH = 1024,
  parameter int LANES = 4,
  localparam int LW = 8,
  localparam int DW = LANES * LW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_en
);
  logic [DW-1:0] mem [DEPTH];
  logic [LANES-1:0] lane_we;
  logic rd_act_q, mask_q, idle_q;

  wire active = sel & ~sleep;
  wire rd_go  = active & gw_n & bwe_n;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = active & (~gw_n | (~bwe_n & ~bsel_n[i]));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (lane_we[i]) mem[addr][i*LW +: LW] <= dq_i[i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o     <= '0;
      rd_act_q <= 1'b0;
      mask_q   <= 1'b0;
      idle_q   <= 1'b1;
    end else begin
      if (rd_go) dq_o <= mem[addr];
      rd_act_q <= rd_go;
      mask_q   <= rd_go & idle_q;
      idle_q   <= ~active;
    end
  end

  assign dq_en = rd_act_q & ~mask_q & ~oe_n & ~sleep;
endmodule

module pbsram_core_chk #(
  parameter int DEPTH = 1024,
  parameter int LANES = 4,
  localparam int DW = LANES * 8,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             sleep,
  input logic [AW-1:0]    addr,
  input logic             gw_n,
  input logic             bwe_n,
  input logic             oe_n,
  input logic [DW-1:0]    dq_o,
  input logic             dq_en
);
  logic prev_idle;
  wire rd_issue = sel & ~sleep & gw_n & bwe_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_idle <= 1'b1;
    else        prev_idle <= ~(sel & ~sleep);

  assert_sleep_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_en);
  assert_oe_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);
  assert_drive_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_en |-> $past(rd_issue));
  assert_first_read_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && prev_idle) |=> !dq_en);
  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !dq_en);
  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_issue |=> $stable(dq_o));
endmodule

bind pbsram_core pbsram_core_chk #(.DEPTH(DEPTH), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .sleep(sleep), .addr(addr),
  .gw_n(gw_n), .bwe_n(bwe_n), .oe_n(oe_n), .dq_o(dq_o), .dq_en(dq_en)
);

// File: tb/tb_pbsram_core.sv
module tb_pbsram_core;
  localparam int DEPTH = 64;
  localparam int LANES = 4;
  localparam int DW = LANES * 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, sleep = 1'b0, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [LANES-1:0] bsel_n = '1;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_en;

  always #4 clk = ~clk;

  pbsram_core #(.DEPTH(DEPTH), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sleep(sleep), .addr(addr),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  typedef struct {
    bit          en;
    bit          chk_data;
    logic [DW-1:0] data;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] last_rd = '0;
  bit have_rd = 0, prev_active = 0, done = 0;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit s, bit slp, bit g, bit b, logic [LANES-1:0] bs,
                     int a, logic [DW-1:0] d, bit oe, string tag);
    item_t it;
    bit act, rd;
    sel = s; sleep = slp; gw_n = g; bwe_n = b; bsel_n = bs;
    addr = AW'(a); dq_i = d; oe_n = oe;
    act = s && !slp;
    rd  = act && g && b;
    if (act && !g) ref_mem[a] = d;
    else if (act && !b)
      for (int i = 0; i < LANES; i++)
        if (!bs[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
    if (rd) begin last_rd = ref_mem[a]; have_rd = 1; end
    it.en = rd && prev_active && !oe;
    it.chk_data = have_rd;
    it.data = last_rd;
    it.tag = tag;
    prev_active = act;
    @(posedge clk);
    q.push_back(it);
    #5;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check({it.tag, " dq_en"}, {{(DW-1){1'b0}}, dq_en}, {{(DW-1){1'b0}}, it.en});
        if (it.chk_data) check({it.tag, " dq_o"}, dq_o, it.data);
      end
    end
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset dq_en", {{(DW-1){1'b0}}, dq_en}, '0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    // R1: whole-word writes, lane controls ignored
    cyc(1,0,0,1,4'hF, 5, 32'h11223344, 0, "R1");
    cyc(1,0,0,0,4'b1010, 6, 32'hA5A5A5A5, 0, "R1");
    cyc(1,0,0,1,4'h0, 7, 32'h0BADF00D, 0, "R1");
    cyc(1,0,0,1,4'hF, DEPTH-1, 32'hCAFEBEEF, 0, "R1");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R4");
    cyc(1,0,1,1,4'hF, 6, 32'h0, 0, "R4");
    // R2: lane writes
    cyc(1,0,1,0,4'b0101, 5, 32'hDEADBEEF, 0, "R2");
    cyc(1,0,1,0,4'b1110, 6, 32'h000000FF, 0, "R2");
    cyc(1,0,1,0,4'b1111, 7, 32'hFFFFFFFF, 0, "R2");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R2");
    cyc(1,0,1,1,4'hF, 6, 32'h0, 0, "R2");
    cyc(1,0,1,1,4'hF, 7, 32'h0, 0, "R2");
    // R3: lane selects low without write enables
    cyc(1,0,1,1,4'h0, 6, 32'h55555555, 0, "R3");
    cyc(1,0,1,1,4'hF, 6, 32'h0, 0, "R3");
    // R5: output enable gating
    cyc(1,0,1,1,4'hF, 5, 32'h0, 1, "R5");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R5");
    cyc(1,0,1,1,4'hF, DEPTH-1, 32'h0, 1, "R5");
    cyc(1,0,1,1,4'hF, DEPTH-1, 32'h0, 0, "R4");
    // R8 and R9: deselect blocks a write and holds data
    cyc(0,0,0,1,4'h0, 7, 32'h99999999, 0, "R8");
    cyc(0,0,1,1,4'hF, 5, 32'h0, 0, "R9");
    // R6: first read after idle masked, then normal
    cyc(1,0,1,1,4'hF, 7, 32'h0, 0, "R6");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R6");
    cyc(1,0,1,1,4'hF, 6, 32'h0, 0, "R6");
    // R7: sleep blocks writes and reads
    cyc(1,1,0,1,4'h0, 5, 32'h77777777, 0, "R7");
    cyc(1,1,1,1,4'hF, 6, 32'h0, 0, "R7");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R7");
    cyc(1,0,1,1,4'hF, 5, 32'h0, 0, "R7");
    // R9: write cycles do not disturb held read data
    cyc(1,0,0,1,4'hF, 8, 32'h12345678, 0, "R9");
    cyc(1,0,1,0,4'h0, 9, 32'h87654321, 0, "R9");
    cyc(1,0,1,1,4'hF, 8, 32'h0, 0, "R1");
    cyc(1,0,1,1,4'hF, 9, 32'h0, 0, "R2");
    cyc(0,0,1,1,4'hF, 0, 32'h0, 0, "R8");
    cyc(0,0,1,1,4'hF, 0, 32'h0, 0, "R9");
    while (q.size() > 0) @(posedge clk);
    #4;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule